// File: doc/BRIEF.md
# Dual-Output Level Interrupt Aggregator

This block gathers up to 32 level-sensitive interrupt sources and drives two request lines to a processor: a normal request line and a fast request line. A soft-interrupt register holds extra request bits that the host writes. Each bit of this register is ORed with the matching external line to form a raw pending vector. Each request line has its own enable mask. The line is asserted while any bit of (raw AND mask) is set.

The host reaches the block over a plain 32-bit register bus. The masks and the soft-interrupt register are never written as a whole word. A write to a "set" offset turns on the bits written as 1. A write to a "clear" offset turns off the bits written as 1. This allows a single source to be masked or unmasked without a read-modify-write. For each line the host can read the raw vector and the masked vector. Masked status that reads zero when a request is taken means the event is spurious.

Top module: `intc_dual_agg`

## Requirements
- R1: After a synchronous reset, both enable masks and the soft-interrupt register are zero, both request lines are low, and every register reads zero while the sources are low.
- R2: A write to 0x08 (normal) or 0x28 (fast) sets every enable bit that is 1 in the data word. Bits written as 0 keep their value.
- R3: A write to 0x0C (normal) or 0x2C (fast) clears every enable bit that is 1 in the data word. Bits written as 0 keep their value.
- R4: Writes to 0x10 set, and writes to 0x14 clear, soft-interrupt bits, with the same write-one rules. Reads of 0x10 or 0x14 return the soft-interrupt register.
- R5: Offsets 0x04 and 0x24 both read the raw vector. Bit n of the raw vector is source n ORed with soft bit n, and the enables have no effect on it.
- R6: Offset 0x00 reads raw AND the normal mask. Offset 0x20 reads raw AND the fast mask. The two masks act independently.
- R7: irq_o is high exactly when the normal masked vector is non-zero, and fiq_o is high exactly when the fast masked vector is non-zero. Both follow their inputs with no clock delay.
- R8: Sources are levels: a status bit and its request line stay set while the source stays high and enabled, and drop when the source drops.
- R9: Reads of 0x08 or 0x0C return the normal mask, and reads of 0x28 or 0x2C return the fast mask. Any offset not listed in R2–R6 reads zero.
- R10: Writing the same word to 0x0C and 0x2C disables those sources on both request lines.
- R11: Read data is registered. It shows the addressed register in the cycle after bus_rd is high, and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Level interrupt source lines, bit n is source n |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal request line |
| fiq_o | output | 1 | Fast request line |

## Verification
The main function is exercised with three kinds of source pattern:
- A sparse pattern with low and middle bits set, under a partial normal mask. This shows that raw status ignores the enables while masked status applies them.
- The top bit alone, pending through the soft register and the fast mask. This shows that the two lines are masked independently and that soft bits merge into the raw vector.
- All sources high after a clear mask written to both paths, which checks that the start-up disable works.

Dropping the source lines then shows level behaviour and a masked read of zero. Read-back of the strobe offsets and of unmapped offsets separates the real registers from holes in the address map.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DATA_W = 32;

    // Byte offsets of the register map
    localparam logic [31:0] OFS_IRQ_STAT = 32'h00;
    localparam logic [31:0] OFS_IRQ_RAW  = 32'h04;
    localparam logic [31:0] OFS_IRQ_ENS  = 32'h08;
    localparam logic [31:0] OFS_IRQ_ENC  = 32'h0C;
    localparam logic [31:0] OFS_SW_SET   = 32'h10;
    localparam logic [31:0] OFS_SW_CLR   = 32'h14;
    localparam logic [31:0] OFS_FIQ_STAT = 32'h20;
    localparam logic [31:0] OFS_FIQ_RAW  = 32'h24;
    localparam logic [31:0] OFS_FIQ_ENS  = 32'h28;
    localparam logic [31:0] OFS_FIQ_ENC  = 32'h2C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_IRQ_STAT,
        SEL_IRQ_RAW,
        SEL_IRQ_ENS,
        SEL_IRQ_ENC,
        SEL_SW_SET,
        SEL_SW_CLR,
        SEL_FIQ_STAT,
        SEL_FIQ_RAW,
        SEL_FIQ_ENS,
        SEL_FIQ_ENC
    } reg_sel_e;

    typedef struct packed {
        logic irq_set;
        logic irq_clr;
        logic fiq_set;
        logic fiq_clr;
        logic sw_set;
        logic sw_clr;
    } wr_strobe_t;

    function automatic reg_sel_e decode_addr(input logic [31:0] a);
        reg_sel_e s;
        case (a)
            OFS_IRQ_STAT: s = SEL_IRQ_STAT;
            OFS_IRQ_RAW:  s = SEL_IRQ_RAW;
            OFS_IRQ_ENS:  s = SEL_IRQ_ENS;
            OFS_IRQ_ENC:  s = SEL_IRQ_ENC;
            OFS_SW_SET:   s = SEL_SW_SET;
            OFS_SW_CLR:   s = SEL_SW_CLR;
            OFS_FIQ_STAT: s = SEL_FIQ_STAT;
            OFS_FIQ_RAW:  s = SEL_FIQ_RAW;
            OFS_FIQ_ENS:  s = SEL_FIQ_ENS;
            OFS_FIQ_ENC:  s = SEL_FIQ_ENC;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic wr_strobe_t write_strobes(input reg_sel_e s, input logic wr);
        wr_strobe_t w;
        w         = '0;
        w.irq_set = wr && (s == SEL_IRQ_ENS);
        w.irq_clr = wr && (s == SEL_IRQ_ENC);
        w.fiq_set = wr && (s == SEL_FIQ_ENS);
        w.fiq_clr = wr && (s == SEL_FIQ_ENC);
        w.sw_set  = wr && (s == SEL_SW_SET);
        w.sw_clr  = wr && (s == SEL_SW_CLR);
        return w;
    endfunction

endpackage

// File: rtl/intc_wo_reg.sv
// Register changed only by write-one-to-set and write-one-to-clear strobes.
module intc_wo_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic [W-1:0] bits_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] set_mask;
    logic [W-1:0] clr_mask;
    logic [W-1:0] q_nxt;

    always_comb begin
        set_mask = set_i ? bits_i : '0;
        clr_mask = clr_i ? bits_i : '0;
        q_nxt    = (q_o | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= q_nxt;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (q_o == '0));

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (set_i && !clr_i) |=> ((q_o & $past(bits_i)) == $past(bits_i)));

    assert_set_keep_R2: assert property (@(posedge clk) disable iff (rst)
        (set_i && !clr_i) |=> ((q_o & ~$past(bits_i)) == ($past(q_o) & ~$past(bits_i))));

    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> ((q_o & $past(bits_i)) == '0));

    assert_clr_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> ((q_o & ~$past(bits_i)) == ($past(q_o) & ~$past(bits_i))));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/intc_path.sv
// One request path: apply its enable mask to the raw vector and reduce to a line.
module intc_path #(
    parameter int W = 32
) (
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] masked_o,
    output logic         line_o
);

    always_comb begin
        masked_o = raw_i & en_i;
        line_o   = |masked_o;
    end

endmodule

// File: rtl/intc_regbus.sv
// Address decode, write strobes and the registered read port.
module intc_regbus
    import intc_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output wr_strobe_t        strobe_o,
    input  logic [W-1:0]      raw_i,
    input  logic [W-1:0]      irq_masked_i,
    input  logic [W-1:0]      irq_en_i,
    input  logic [W-1:0]      fiq_masked_i,
    input  logic [W-1:0]      fiq_en_i,
    input  logic [W-1:0]      soft_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [31:0]        addr_ext;
    reg_sel_e           sel;
    logic [W-1:0]       rd_vec;
    logic [DATA_W-1:0]  rd_word;

    always_comb begin
        addr_ext               = '0;
        addr_ext[ADDR_W-1:0]   = addr_i;
        sel                    = decode_addr(addr_ext);
        strobe_o               = write_strobes(sel, wr_i);
    end

    always_comb begin
        case (sel)
            SEL_IRQ_STAT:            rd_vec = irq_masked_i;
            SEL_IRQ_RAW,
            SEL_FIQ_RAW:             rd_vec = raw_i;
            SEL_IRQ_ENS,
            SEL_IRQ_ENC:             rd_vec = irq_en_i;
            SEL_SW_SET,
            SEL_SW_CLR:              rd_vec = soft_i;
            SEL_FIQ_STAT:            rd_vec = fiq_masked_i;
            SEL_FIQ_ENS,
            SEL_FIQ_ENC:             rd_vec = fiq_en_i;
            default:                 rd_vec = '0;
        endcase
        rd_word         = '0;
        rd_word[W-1:0]  = rd_vec;
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_o <= '0;
        else if (rd_i) rdata_o <= rd_word;
    end

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_i && sel == SEL_NONE) |=> (rdata_o == '0));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(rdata_o));

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));

endmodule

// File: rtl/intc_dual_agg.sv
module intc_dual_agg
    import intc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);

    localparam int N_PATH = 2;
    localparam int P_IRQ  = 0;
    localparam int P_FIQ  = 1;

    wr_strobe_t         stb;
    logic [N_SRC-1:0]   wbits;
    logic [N_SRC-1:0]   soft_q;
    logic [N_SRC-1:0]   raw;
    logic [N_SRC-1:0]   en_q   [N_PATH];
    logic [N_SRC-1:0]   masked [N_PATH];
    logic [N_PATH-1:0]  line;
    logic [N_PATH-1:0]  set_v;
    logic [N_PATH-1:0]  clr_v;

    assign wbits = bus_wdata[N_SRC-1:0];
    assign raw   = src_i | soft_q;

    assign set_v[P_IRQ] = stb.irq_set;
    assign clr_v[P_IRQ] = stb.irq_clr;
    assign set_v[P_FIQ] = stb.fiq_set;
    assign clr_v[P_FIQ] = stb.fiq_clr;

    intc_wo_reg #(.W(N_SRC)) u_soft (
        .clk    (clk),
        .rst    (rst),
        .set_i  (stb.sw_set),
        .clr_i  (stb.sw_clr),
        .bits_i (wbits),
        .q_o    (soft_q)
    );

    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        intc_wo_reg #(.W(N_SRC)) u_en (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[p]),
            .clr_i  (clr_v[p]),
            .bits_i (wbits),
            .q_o    (en_q[p])
        );
        intc_path #(.W(N_SRC)) u_path (
            .raw_i    (raw),
            .en_i     (en_q[p]),
            .masked_o (masked[p]),
            .line_o   (line[p])
        );
    end

    assign irq_o = line[P_IRQ];
    assign fiq_o = line[P_FIQ];

    intc_regbus #(.W(N_SRC), .ADDR_W(ADDR_W)) u_bus (
        .clk          (clk),
        .rst          (rst),
        .addr_i       (bus_addr),
        .wr_i         (bus_wr),
        .rd_i         (bus_rd),
        .strobe_o     (stb),
        .raw_i        (raw),
        .irq_masked_i (masked[P_IRQ]),
        .irq_en_i     (en_q[P_IRQ]),
        .fiq_masked_i (masked[P_FIQ]),
        .fiq_en_i     (en_q[P_FIQ]),
        .soft_i       (soft_q),
        .rdata_o      (bus_rdata)
    );

    assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ($countones(en_q[P_IRQ]) != 0));

    assert_fiq_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> ($countones(en_q[P_FIQ]) != 0));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (src_i == '0 && soft_q == '0) |-> (!irq_o && !fiq_o));

endmodule

// File: tb/test_intc_dual_agg.sv
module test_intc_dual_agg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        fiq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    intc_dual_agg #(.N_SRC(32), .ADDR_W(8)) i_intc_dual_agg (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic t_reset;
        expect_reg("R1 irq stat", 8'h00, 32'h0);
        expect_reg("R1 raw", 8'h04, 32'h0);
        expect_reg("R1 irq en", 8'h08, 32'h0);
        expect_reg("R1 soft", 8'h10, 32'h0);
        expect_reg("R1 fiq en", 8'h28, 32'h0);
        check("R1 irq_o", {31'b0, irq_o}, 32'h0);
        check("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
    endtask

    task automatic t_enable_set;
        bus_write(8'h08, 32'h0000_00F0);
        expect_reg("R2 set first", 8'h08, 32'h0000_00F0);
        bus_write(8'h08, 32'h0000_000F);
        expect_reg("R2 set keeps", 8'h08, 32'h0000_00FF);
        expect_reg("R9 read enc offset", 8'h0C, 32'h0000_00FF);
        expect_reg("R2 fiq untouched", 8'h28, 32'h0);
    endtask

    task automatic t_enable_clear;
        bus_write(8'h0C, 32'h0000_0030);
        expect_reg("R3 clear", 8'h08, 32'h0000_00CF);
    endtask

    task automatic t_raw_masked;
        @(negedge clk);
        src_i = 32'h0000_0101;
        #1;
        check("R7 irq_o high", {31'b0, irq_o}, 32'h1);
        check("R7 fiq_o low", {31'b0, fiq_o}, 32'h0);
        expect_reg("R5 irq raw", 8'h04, 32'h0000_0101);
        expect_reg("R5 fiq raw", 8'h24, 32'h0000_0101);
        expect_reg("R6 irq masked", 8'h00, 32'h0000_0001);
        expect_reg("R6 fiq masked", 8'h20, 32'h0);
    endtask

    task automatic t_level;
        @(negedge clk);
        src_i = 32'h0;
        #1;
        check("R8 irq_o drops", {31'b0, irq_o}, 32'h0);
        expect_reg("R8 masked zero", 8'h00, 32'h0);
    endtask

    task automatic t_soft;
        bus_write(8'h10, 32'h8000_0004);
        expect_reg("R4 soft set", 8'h10, 32'h8000_0004);
        expect_reg("R4 soft via clr ofs", 8'h14, 32'h8000_0004);
        expect_reg("R5 raw has soft", 8'h04, 32'h8000_0004);
        check("R7 irq_o from soft", {31'b0, irq_o}, 32'h1);
        bus_write(8'h14, 32'h0000_0004);
        expect_reg("R4 soft clear", 8'h10, 32'h8000_0000);
        check("R7 irq_o off", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_fiq;
        bus_write(8'h28, 32'h8000_0000);
        #1;
        check("R7 fiq_o high", {31'b0, fiq_o}, 32'h1);
        check("R6 irq_o independent", {31'b0, irq_o}, 32'h0);
        expect_reg("R6 fiq masked", 8'h20, 32'h8000_0000);
        expect_reg("R6 irq masked", 8'h00, 32'h0);
        expect_reg("R9 fiq enc offset", 8'h2C, 32'h8000_0000);
        bus_write(8'h14, 32'h8000_0000);
        #1;
        check("R8 fiq_o drops", {31'b0, fiq_o}, 32'h0);
    endtask

    task automatic t_clear_both;
        bus_write(8'h28, 32'h0000_FFFF);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h2C, 32'hFFFF_FFFF);
        @(negedge clk);
        src_i = 32'hFFFF_FFFF;
        #1;
        check("R10 irq_o off", {31'b0, irq_o}, 32'h0);
        check("R10 fiq_o off", {31'b0, fiq_o}, 32'h0);
        expect_reg("R10 irq en", 8'h08, 32'h0);
        expect_reg("R10 fiq en", 8'h28, 32'h0);
        expect_reg("R5 raw all", 8'h24, 32'hFFFF_FFFF);
    endtask

    task automatic t_unmapped;
        expect_reg("R9 hole 0x18", 8'h18, 32'h0);
        expect_reg("R9 hole 0x1C", 8'h1C, 32'h0);
        expect_reg("R9 hole 0x30", 8'h30, 32'h0);
        expect_reg("R9 misaligned", 8'h05, 32'h0);
    endtask

    task automatic t_hold;
        expect_reg("R11 read raw", 8'h04, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'h0000_0001);
        @(negedge clk);
        src_i = 32'h0;
        bus_addr = 8'h00;
        @(negedge clk);
        check("R11 rdata held", bus_rdata, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset_again;
        bus_write(8'h10, 32'h0000_00AA);
        bus_write(8'h28, 32'h0000_00AA);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 lines after reset", {30'b0, irq_o, fiq_o}, 32'h0);
        expect_reg("R1 soft after reset", 8'h10, 32'h0);
        expect_reg("R1 fiq en after reset", 8'h28, 32'h0);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable_set();
        t_enable_clear();
        t_raw_masked();
        t_level();
        t_soft();
        t_fiq();
        t_clear_both();
        t_unmapped();
        t_hold();
        t_reset_again();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule